// File: doc/BRIEF.md
# UART Oscillator Sleep Controller

This block decides when a group of UART channels may stop their shared clock oscillator. Each channel reports its idle status: an interrupt-clear flag, four modem-change flags, the raw receive pin, the low byte of its baud divisor, and two FIFO-empty flags. The block drives a single oscillator-enable output, which falls when sleep is permitted and comes back when software withdraws permission.

Software grants sleep in one of two ways. The first is a per-channel enable bit in the interrupt-enable register. That bit can only be written after a guarded sequence. Software first loads the line-control register with the key value 0xBF, which opens the extended-feature register. It then sets bit 4 of that register, and finally clears line-control bit 7. The second way is a global sleep register with one bit per channel. Once the block is asleep, it stays asleep whatever the status inputs do, until software clears an enable bit.

Top module: `uart_nap_ctrl`

## Requirements
- R1: After reset, osc_en is 1, asleep is 0, and every register reads 0.
- R2: A write to the extended-feature register (address 2) takes effect only while that channel's line-control register (address 3) holds 0xBF. Any other write to address 2 leaves it unchanged.
- R3: A write to the interrupt-enable register (address 1) is ignored while line-control bit 7 is 1. When line-control bit 7 is 0, the write always updates bits 7..5 and 3..0. Bit 4 of that write is applied only if extended-feature bit 4 is 1, and is ignored otherwise.
- R4: The global sleep register (address 4, any channel select) holds bit c as channel c's sleep grant. Bits at or above NCH read back as 0, so writing 0xFF grants sleep on all channels.
- R5: A channel's enable is interrupt-enable bit 4 OR its sleep-register bit. Sleep needs the enable of every channel.
- R6: Sleep also needs every channel to be quiet. A quiet channel has its interrupt-clear flag at 1, all four modem-change flags at 0, the synchronized RX pin at 1, a non-zero divisor byte, and both FIFO-empty flags at 1. If any one of these fails on any channel, sleep is blocked.
- R7: osc_en falls one clock edge after the edge at which all enables and all quiet conditions first hold together.
- R8: The RX pin passes through two flops, reset to 1, before the quiet check. A rise of the pin therefore permits sleep only after two edges.
- R9: While asleep with all enables still set, status changes on any channel do not raise osc_en.
- R10: osc_en returns to 1 in the same cycle that any channel's enable becomes 0.
- R11: The asleep output is always the inverse of osc_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | CW | Channel selected for the write |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 8 | Write data |
| rd_chan | input | CW | Channel selected for the read |
| rd_addr | input | 3 | Register address of the read |
| rd_data | output | 8 | Read data (combinational) |
| no_irq | input | NCH | Per channel: 1 when no interrupt is pending |
| msr_delta | input | 4*NCH | Per channel: modem-change flags |
| rx_pin | input | NCH | Raw asynchronous receive pins |
| div_lo | input | 8*NCH | Per channel: low byte of the baud divisor |
| tx_empty | input | NCH | Per channel: transmit FIFO is empty |
| rx_empty | input | NCH | Per channel: receive FIFO is empty |
| osc_en | output | 1 | Oscillator enable |
| asleep | output | 1 | Current sleep state |

## Verification
The main sweep drives one channel at a time through all 32 combinations of its five quiet conditions, while the other channels stay quiet and sleep is granted through the global register. Only the all-good combination may lower osc_en, so the sweep shows that each condition alone blocks entry on each channel. The guarded register sequence is exercised three ways: with the wrong key, with line-control bit 7 set, and with feature bit 4 clear. These show which writes are dropped. Separate patterns check the following: a partial grant, entry through the interrupt-enable path, RX synchronizer latency, status changes during sleep, and immediate wake when an enable is cleared.

// File: rtl/uart_nap_pkg.sv
package uart_nap_pkg;
  localparam int          ADDR_W     = 3;
  localparam logic [2:0]  A_IER      = 3'd1;
  localparam logic [2:0]  A_FEAT     = 3'd2;
  localparam logic [2:0]  A_LINE     = 3'd3;
  localparam logic [2:0]  A_NAP      = 3'd4;
  localparam logic [7:0]  UNLOCK_KEY = 8'hBF;
  localparam int          NAP_BIT    = 4;
  localparam int          DLAB_BIT   = 7;

  // a channel may let the oscillator stop only when every idle test passes
  function automatic logic chan_quiet(input logic       irq_clear,
                                      input logic [3:0] delta,
                                      input logic       rx_mark,
                                      input logic [7:0] div,
                                      input logic       txe,
                                      input logic       rxe);
    return irq_clear && (delta == 4'd0) && rx_mark && (div != 8'd0) && txe && rxe;
  endfunction

  // new interrupt-enable value from a write; the sleep bit is guarded
  function automatic logic [7:0] ier_next(input logic [7:0] cur,
                                          input logic [7:0] wd,
                                          input logic       unlocked);
    logic [7:0] n;
    n = wd;
    if (!unlocked) n[NAP_BIT] = cur[NAP_BIT];
    return n;
  endfunction
endpackage

// File: rtl/uart_nap_regs.sv
module uart_nap_regs
  import uart_nap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       line_q,
  output logic [7:0]       feat_q,
  output logic [7:0]       ier_q
);
  logic line_wr, feat_wr, ier_wr;

  assign line_wr = wr_hit && (wr_addr == A_LINE);
  assign feat_wr = wr_hit && (wr_addr == A_FEAT) && (line_q == UNLOCK_KEY);
  assign ier_wr  = wr_hit && (wr_addr == A_IER) && !line_q[DLAB_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      feat_q <= '0;
      ier_q  <= '0;
    end else begin
      if (line_wr) line_q <= wr_data;
      if (feat_wr) feat_q <= wr_data;
      if (ier_wr)  ier_q  <= ier_next(ier_q, wr_data, feat_q[NAP_BIT]);
    end
  end

  // R2
  feat_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(feat_q) |-> $past(line_q) == UNLOCK_KEY);

  // R3
  nap_bit_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ier_q[NAP_BIT]) |-> $past(feat_q[NAP_BIT]));

  // R3
  ier_dlab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ier_q) |-> !$past(line_q[DLAB_BIT]));
endmodule

// File: rtl/uart_nap_sync.sv
module uart_nap_sync #(
  parameter int   W        = 4,
  parameter logic RESET_LV = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] mid_q, out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= {W{RESET_LV}};
      out_q <= {W{RESET_LV}};
    end else begin
      mid_q <= d_async;
      out_q <= mid_q;
    end
  end

  assign d_sync = out_q;

  // R8
  two_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> out_q == $past(mid_q));
endmodule

// File: rtl/uart_nap_qual.sv
module uart_nap_qual
  import uart_nap_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0]   no_irq,
  input  logic [4*NCH-1:0] msr_delta,
  input  logic [NCH-1:0]   rx_mark,
  input  logic [8*NCH-1:0] div_lo,
  input  logic [NCH-1:0]   tx_empty,
  input  logic [NCH-1:0]   rx_empty,
  output logic [NCH-1:0]   quiet
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign quiet[c] = chan_quiet(no_irq[c], msr_delta[4*c +: 4], rx_mark[c],
                                 div_lo[8*c +: 8], tx_empty[c], rx_empty[c]);
  end
endmodule

// File: rtl/uart_nap_ctrl.sv
module uart_nap_ctrl
  import uart_nap_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_chan,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [CW-1:0]     rd_chan,
  input  logic [2:0]        rd_addr,
  output logic [7:0]        rd_data,
  input  logic [NCH-1:0]    no_irq,
  input  logic [4*NCH-1:0]  msr_delta,
  input  logic [NCH-1:0]    rx_pin,
  input  logic [8*NCH-1:0]  div_lo,
  input  logic [NCH-1:0]    tx_empty,
  input  logic [NCH-1:0]    rx_empty,
  output logic              osc_en,
  output logic              asleep
);
  localparam int NAP_W = (NCH < 8) ? NCH : 8;

  logic [7:0]     line_a [NCH];
  logic [7:0]     feat_a [NCH];
  logic [7:0]     ier_a  [NCH];
  logic [NCH-1:0] en_vec;
  logic [NCH-1:0] quiet;
  logic [NCH-1:0] rx_mark;
  logic [7:0]     nap_q;
  logic           all_en, all_quiet, asleep_q, nap_wr;

  for (genvar c = 0; c < NCH; c++) begin : g_regs
    uart_nap_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_en && (wr_chan == CW'(c))),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .line_q  (line_a[c]),
      .feat_q  (feat_a[c]),
      .ier_q   (ier_a[c])
    );
    assign en_vec[c] = ier_a[c][NAP_BIT] | nap_q[c];
  end

  assign nap_wr = wr_en && (wr_addr == A_NAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nap_q <= '0;
    else if (nap_wr) nap_q <= {{(8-NAP_W){1'b0}}, wr_data[NAP_W-1:0]};
  end

  uart_nap_sync #(.W(NCH), .RESET_LV(1'b1)) u_rx_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rx_pin),
    .d_sync  (rx_mark)
  );

  uart_nap_qual #(.NCH(NCH)) u_qual (
    .no_irq    (no_irq),
    .msr_delta (msr_delta),
    .rx_mark   (rx_mark),
    .div_lo    (div_lo),
    .tx_empty  (tx_empty),
    .rx_empty  (rx_empty),
    .quiet     (quiet)
  );

  assign all_en    = &en_vec;
  assign all_quiet = &quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         asleep_q <= 1'b0;
    else if (!all_en)   asleep_q <= 1'b0;
    else if (all_quiet) asleep_q <= 1'b1;
  end

  assign osc_en = !(asleep_q && all_en);
  assign asleep = asleep_q && all_en;

  always_comb begin
    rd_data = 8'h00;
    case (rd_addr)
      A_IER:  rd_data = ier_a[rd_chan];
      A_FEAT: rd_data = feat_a[rd_chan];
      A_LINE: rd_data = line_a[rd_chan];
      A_NAP:  rd_data = nap_q;
      default: rd_data = 8'h00;
    endcase
  end

  // R7
  enter_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (all_en && all_quiet && osc_en) |=> (!osc_en || !all_en));

  // R6
  entry_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> $past(all_quiet) && $past(all_en));

  // R9
  hold_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> (!osc_en || !all_en));

  // R10
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> !all_en);

  // R11
  status_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep != osc_en);
endmodule

// File: tb/uart_nap_ctrl_tb.sv
module uart_nap_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [CW-1:0]     wr_chan = '0;
  logic [2:0]        wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [CW-1:0]     rd_chan = '0;
  logic [2:0]        rd_addr = '0;
  logic [7:0]        rd_data;
  logic [NCH-1:0]    no_irq;
  logic [4*NCH-1:0]  msr_delta;
  logic [NCH-1:0]    rx_pin;
  logic [8*NCH-1:0]  div_lo;
  logic [NCH-1:0]    tx_empty;
  logic [NCH-1:0]    rx_empty;
  logic              osc_en, asleep;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_nap_ctrl #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_chan(rd_chan), .rd_addr(rd_addr), .rd_data(rd_data),
    .no_irq(no_irq), .msr_delta(msr_delta), .rx_pin(rx_pin), .div_lo(div_lo),
    .tx_empty(tx_empty), .rx_empty(rx_empty), .osc_en(osc_en), .asleep(asleep)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_chan = CW'(ch); wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int ch, input logic [2:0] a, input logic [7:0] exp);
    rd_chan = CW'(ch); rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic all_quiet();
    no_irq = '1; msr_delta = '0; rx_pin = '1; tx_empty = '1; rx_empty = '1;
    for (int c = 0; c < NCH; c++) div_lo[8*c +: 8] = 8'd12 + 8'(c);
  endtask

  // bit0 irq clear, bit1 no modem change, bit2 rx high, bit3 divisor non-zero, bit4 fifos empty
  task automatic set_chan(input int ch, input int v);
    no_irq[ch]             = v[0];
    msr_delta[4*ch +: 4]   = v[1] ? 4'd0 : (4'd1 << (ch % 4));
    rx_pin[ch]             = v[2];
    div_lo[8*ch +: 8]      = v[3] ? 8'd5 : 8'd0;
    tx_empty[ch]           = v[4];
    rx_empty[ch]           = v[4];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    all_quiet();
    ticks(3);
    rst_n = 1'b1;
    ticks(1);
    // R1 reset state
    #1;
    check("R1 osc_en", osc_en, 1);
    check("R1 asleep", asleep, 0);
    for (int c = 0; c < NCH; c++) begin
      rd_chk("R1 ier", c, 3'd1, 8'h00);
      rd_chk("R1 feat", c, 3'd2, 8'h00);
      rd_chk("R1 line", c, 3'd3, 8'h00);
    end
    rd_chk("R1 nap", 0, 3'd4, 8'h00);

    // R2 feature write blocked without the key
    wr(0, 3'd3, 8'h03);
    wr(0, 3'd2, 8'h10);
    rd_chk("R2 feat locked", 0, 3'd2, 8'h00);
    wr(0, 3'd3, 8'hBE);
    wr(0, 3'd2, 8'h10);
    rd_chk("R2 feat near key", 0, 3'd2, 8'h00);

    // R3 ier: bit4 dropped while feature bit4 clear
    wr(0, 3'd3, 8'h03);
    wr(0, 3'd1, 8'hFF);
    rd_chk("R3 ier bit4 guarded", 0, 3'd1, 8'hEF);
    // R3 ier write ignored while line bit7 set
    wr(0, 3'd3, 8'h83);
    wr(0, 3'd1, 8'h00);
    rd_chk("R3 ier dlab", 0, 3'd1, 8'hEF);

    // unlock sequence on every channel, then grant through ier bit4
    for (int c = 0; c < NCH; c++) begin
      wr(c, 3'd3, 8'hBF);
      wr(c, 3'd2, 8'h10);
      rd_chk("R2 feat unlocked", c, 3'd2, 8'h10);
      wr(c, 3'd3, 8'h03);
      wr(c, 3'd1, 8'h10);
      rd_chk("R3 ier bit4 set", c, 3'd1, 8'h10);
    end
    // last grant happened at the edge just passed; one more edge to sleep (R5, R7)
    #1;
    check("R7 not yet", osc_en, 1);
    ticks(1); #1;
    check("R5 ier path sleeps", osc_en, 0);
    check("R11 asleep", asleep, 1);
    // R10: clear channel 1 grant
    wr(1, 3'd1, 8'h00);
    #1;
    check("R10 wake on clear", osc_en, 1);
    check("R11 awake", asleep, 0);
    for (int c = 0; c < NCH; c++) wr(c, 3'd1, 8'h00);

    // R4 partial grant and read-back
    wr(0, 3'd4, 8'h0E);
    rd_chk("R4 nap readback", 2, 3'd4, 8'h0E);
    ticks(2); #1;
    check("R5 partial grant blocks", osc_en, 1);
    wr(0, 3'd4, 8'hFF);
    rd_chk("R4 nap all", 0, 3'd4, 8'h0F);
    ticks(1); #1;
    check("R4 0xFF sleeps", osc_en, 0);

    // R9: status turns busy while asleep
    no_irq = '0; rx_pin = '0; msr_delta = '1; tx_empty = '0;
    ticks(5); #1;
    check("R9 stays asleep", osc_en, 0);
    wr(0, 3'd4, 8'h00);
    #1;
    check("R10 wake via nap reg", osc_en, 1);
    all_quiet();
    ticks(3);

    // R8: rx sync latency on channel 2
    rx_pin[2] = 1'b0;
    ticks(3);
    wr(0, 3'd4, 8'h0F);
    ticks(3); #1;
    check("R8 rx low blocks", osc_en, 1);
    rx_pin[2] = 1'b1;
    ticks(1); #1;
    check("R8 one edge", osc_en, 1);
    ticks(1); #1;
    check("R8 two edges", osc_en, 1);
    ticks(1); #1;
    check("R8 three edges sleeps", osc_en, 0);
    wr(0, 3'd4, 8'h00);
    all_quiet();
    ticks(3);

    // R6 sweep: every quiet-condition combination on each channel
    for (int ch = 0; ch < NCH; ch++) begin
      for (int v = 0; v < 32; v++) begin
        all_quiet();
        set_chan(ch, v);
        ticks(3);
        wr(0, 3'd4, 8'hFF);
        #1;
        check("R7 same edge", osc_en, 1);
        ticks(1); #1;
        check("R6 sweep", osc_en, (v == 31) ? 1'b0 : 1'b1);
        check("R11 sweep", asleep, (v == 31) ? 1'b1 : 1'b0);
        wr(0, 3'd4, 8'h00);
        #1;
        check("R10 sweep wake", osc_en, 1);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule